// File: doc/BRIEF.md
# Zero-Crossing Gated Gain Updater

This block decides, for each audio channel, when a freshly received gain code replaces the gain code in force. A serial control port delivers one code per channel together with a single-cycle update strobe. A stream of signed samples arrives for each channel, and the block uses it to find the moments when the waveform passes through zero. With gating switched off, a new code is applied at once. With gating switched on, the change is held until the channel's waveform has crossed zero twice, so the level step lands where it is least audible. A timer forces the change through if a quiet or DC input never produces those crossings.

An active-low mute pin silences both channels. Each channel mutes at its own next zero crossing or timeout, and this gating applies even when the enable input is low. The mute pin is only looked at while chip select is high, so a mute asserted in the middle of a serial transfer waits for the transfer to end. A gain code of zero also silences its channel. The outputs are the applied code of each channel and a per-channel silenced flag, which drive the tap selection of the analog path.

Top module: `zc_gain_updater`

## Requirements
- R1: After synchronous reset every applied code is 0 and every silenced flag is 1.
- R2: With `zc_en` low, a strobe puts each channel's code on `act_gain` in the cycle after the strobe edge.
- R3: With `zc_en` high, a code that differs from the applied one is held. It is applied on the clock edge that samples the second zero crossing after the strobe. Before that edge the applied code does not change.
- R4: A zero crossing is a valid sample whose MSB (two's-complement sign) differs from the MSB of the previous valid sample on that channel, or a valid sample that is all zeros. A cycle with `smp_valid` low is not a crossing and leaves the remembered sign unchanged. A valid sample with the same sign is not a crossing.
- R5: If no second crossing arrives, the held code is applied TIMEOUT_CYCLES = (CLK_HZ/1000)*TIMEOUT_MS edges after the strobe edge.
- R6: A new strobe that arrives while a code is held replaces that code and restarts both the timer and the crossing count for that channel.
- R7: While the applied code of a channel is 0, its silenced flag is 1. A nonzero code clears the flag unless the mute pin has silenced the channel.
- R8: Once the mute request has been sampled low, each channel's flag rises at that channel's next crossing or timeout, whatever the level of `zc_en`. `act_gain` is left unchanged.
- R9: `mute_n` is sampled only on cycles where `cs_n` is high. While `cs_n` is low, the sampled mute request holds its value.
- R10: When the sampled mute request returns high, a pin-caused silence ends in the next cycle, and a mute still waiting for its event is dropped.
- R11: Channels are independent. Channel c uses bits [c*8 +: 8] of `upd_code` and `act_gain`, bits [c*SAMPLE_W +: SAMPLE_W] of `smp_data`, and bit c of the other per-channel vectors.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| upd_stb | input | 1 | One-cycle strobe: new codes for all channels are on `upd_code` |
| upd_code | input | NUM_CH*8 | New gain codes, one byte per channel |
| zc_en | input | 1 | High: gain changes wait for zero crossings |
| mute_n | input | 1 | Mute request for all channels, active low |
| cs_n | input | 1 | Serial transfer in progress when low |
| smp_valid | input | NUM_CH | Sample strobe per channel |
| smp_data | input | NUM_CH*SAMPLE_W | Signed sample per channel |
| act_gain | output | NUM_CH*8 | Applied gain code per channel |
| ch_muted | output | NUM_CH | Channel is silenced (code 0 or pin mute) |

## Verification
The bench builds the block with CLK_HZ = 2000 and TIMEOUT_MS = 16. This shrinks the fallback window to 32 cycles, so the checks can land on the exact edge before and after a timeout, and on a window that a replacing strobe restarted. Two 16-bit channels are kept, so one channel can be muted by a crossing while the other waits for its timeout. A zero-valued sample, an invalid cycle and a same-sign sample are each placed between real crossings.

// File: rtl/zcg_pkg.sv
package zcg_pkg;

    localparam int GAIN_BITS = 8;

    typedef logic [GAIN_BITS-1:0] gain_t;

    localparam gain_t GAIN_SILENT = '0;

    // A code waiting for its moment to be applied.
    typedef struct packed {
        logic  valid;
        gain_t code;
    } held_t;

    // Why the applied code changes in a given cycle.
    typedef enum logic [1:0] {
        APPLY_NONE   = 2'd0,
        APPLY_DIRECT = 2'd1,
        APPLY_ZC     = 2'd2,
        APPLY_TMO    = 2'd3
    } apply_e;

    function automatic logic is_crossing(
        input logic have_prev,
        input logic prev_neg,
        input logic cur_neg,
        input logic cur_zero
    );
        return cur_zero || (have_prev && (prev_neg != cur_neg));
    endfunction

    function automatic int timeout_cycles(input int clk_hz, input int ms);
        int c;
        c = (clk_hz / 1000) * ms;
        return (c < 2) ? 2 : c;
    endfunction

endpackage

// File: rtl/zcg_xdet.sv
module zcg_xdet
    import zcg_pkg::*;
#(
    parameter int SAMPLE_W = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                valid,
    input  logic [SAMPLE_W-1:0] data,
    output logic                xing
);

    logic prev_neg_q;
    logic have_prev_q;
    logic cur_neg;
    logic cur_zero;

    always_comb begin
        cur_neg  = data[SAMPLE_W-1];
        cur_zero = (data == '0);
        xing     = valid && is_crossing(have_prev_q, prev_neg_q, cur_neg, cur_zero);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_neg_q  <= 1'b0;
            have_prev_q <= 1'b0;
        end else if (valid) begin
            prev_neg_q  <= cur_neg;
            have_prev_q <= 1'b1;
        end
    end

    AST_XING_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
        !valid |-> !xing); // R4

endmodule

// File: rtl/zcg_mute_gate.sv
module zcg_mute_gate (
    input  logic clk,
    input  logic rst,
    input  logic mute_n,
    input  logic cs_n,
    output logic mute_req
);

    always_ff @(posedge clk) begin
        if (rst) begin
            mute_req <= 1'b0;
        end else if (cs_n) begin
            mute_req <= !mute_n;
        end
    end

    AST_MUTE_DEFER: assert property (@(posedge clk) disable iff (rst)
        !cs_n |=> $stable(mute_req)); // R9

endmodule

// File: rtl/zcg_chan.sv
module zcg_chan
    import zcg_pkg::*;
#(
    parameter int TMO_CYCLES = 800000
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  zc_en,
    input  logic  load,
    input  gain_t new_code,
    input  logic  xing,
    input  logic  mute_req,
    output gain_t active_code,
    output logic  muted
);

    localparam int TW = (TMO_CYCLES > 1) ? $clog2(TMO_CYCLES) : 1;
    localparam logic [TW-1:0] TMO_LAST = TW'(TMO_CYCLES - 1);

    held_t         held_q;
    logic          mute_on_q;
    logic          one_seen_q;
    logic [TW-1:0] timer_q;

    logic   mute_wait;
    logic   busy;
    logic   restart;
    logic   tmo_hit;
    logic   window_clear;
    apply_e cause;

    always_comb begin
        mute_wait = mute_req && !mute_on_q;
        busy      = held_q.valid || mute_wait;
        restart   = load && zc_en;
        tmo_hit   = busy && !restart && (timer_q == TMO_LAST);

        cause = APPLY_NONE;
        if (load && !zc_en) begin
            cause = APPLY_DIRECT;
        end else if (!load && held_q.valid) begin
            if (!zc_en) begin
                cause = APPLY_DIRECT;
            end else if (xing && one_seen_q) begin
                cause = APPLY_ZC;
            end else if (tmo_hit) begin
                cause = APPLY_TMO;
            end
        end

        window_clear = restart || !busy || tmo_hit ||
                       (cause == APPLY_ZC) || (cause == APPLY_TMO);
        muted = mute_on_q || (active_code == GAIN_SILENT);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            held_q      <= '0;
            active_code <= GAIN_SILENT;
            mute_on_q   <= 1'b0;
            one_seen_q  <= 1'b0;
            timer_q     <= '0;
        end else begin
            case (cause)
                APPLY_DIRECT: active_code <= load ? new_code : held_q.code;
                APPLY_ZC,
                APPLY_TMO:    active_code <= held_q.code;
                default:      active_code <= active_code;
            endcase

            if (load) begin
                held_q.valid <= zc_en && (new_code != active_code);
                held_q.code  <= new_code;
            end else if (cause != APPLY_NONE) begin
                held_q.valid <= 1'b0;
            end

            if (!mute_req) begin
                mute_on_q <= 1'b0;
            end else if (mute_wait && (xing || tmo_hit)) begin
                mute_on_q <= 1'b1;
            end

            if (window_clear) begin
                one_seen_q <= 1'b0;
                timer_q    <= '0;
            end else begin
                timer_q <= timer_q + 1'b1;
                if (xing && held_q.valid) begin
                    one_seen_q <= 1'b1;
                end
            end
        end
    end

    AST_DIRECT_LOAD: assert property (@(posedge clk) disable iff (rst)
        (load && !zc_en) |=> (active_code == $past(new_code))); // R2

    AST_GATED_HOLD: assert property (@(posedge clk) disable iff (rst)
        (zc_en && !load && !xing && !tmo_hit) |=> $stable(active_code)); // R3

    AST_TIMER_BOUND: assert property (@(posedge clk) disable iff (rst)
        timer_q <= TMO_LAST); // R5

    AST_MUTE_EVENT: assert property (@(posedge clk) disable iff (rst)
        (mute_wait && !xing && !tmo_hit) |=> !mute_on_q); // R8

    AST_UNMUTE: assert property (@(posedge clk) disable iff (rst)
        !mute_req |=> !mute_on_q); // R10

endmodule

// File: rtl/zc_gain_updater.sv
module zc_gain_updater
    import zcg_pkg::*;
#(
    parameter int NUM_CH     = 2,
    parameter int SAMPLE_W   = 16,
    parameter int CLK_HZ     = 50000000,
    parameter int TIMEOUT_MS = 16
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         upd_stb,
    input  logic [NUM_CH*GAIN_BITS-1:0]  upd_code,
    input  logic                         zc_en,
    input  logic                         mute_n,
    input  logic                         cs_n,
    input  logic [NUM_CH-1:0]            smp_valid,
    input  logic [NUM_CH*SAMPLE_W-1:0]   smp_data,
    output logic [NUM_CH*GAIN_BITS-1:0]  act_gain,
    output logic [NUM_CH-1:0]            ch_muted
);

    localparam int TIMEOUT_CYCLES = timeout_cycles(CLK_HZ, TIMEOUT_MS);

    logic mute_req;

    zcg_mute_gate u_mute_gate (
        .clk      (clk),
        .rst      (rst),
        .mute_n   (mute_n),
        .cs_n     (cs_n),
        .mute_req (mute_req)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic  xing;
        gain_t code_now;

        zcg_xdet #(.SAMPLE_W(SAMPLE_W)) u_xdet (
            .clk   (clk),
            .rst   (rst),
            .valid (smp_valid[c]),
            .data  (smp_data[c*SAMPLE_W +: SAMPLE_W]),
            .xing  (xing)
        );

        zcg_chan #(.TMO_CYCLES(TIMEOUT_CYCLES)) u_chan (
            .clk         (clk),
            .rst         (rst),
            .zc_en       (zc_en),
            .load        (upd_stb),
            .new_code    (upd_code[c*GAIN_BITS +: GAIN_BITS]),
            .xing        (xing),
            .mute_req    (mute_req),
            .active_code (code_now),
            .muted       (ch_muted[c])
        );

        assign act_gain[c*GAIN_BITS +: GAIN_BITS] = code_now;
    end

    AST_RESET_STATE: assert property (@(posedge clk)
        rst |=> ((act_gain == '0) && (ch_muted == '1))); // R1

endmodule

// File: tb/zc_gain_updater_bench.sv
module zc_gain_updater_bench;

    localparam int NCH = 2;
    localparam int SW  = 16;
    localparam int TMO = 32;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             upd_stb = 1'b0;
    logic [NCH*8-1:0] upd_code = '0;
    logic             zc_en = 1'b0;
    logic             mute_n = 1'b1;
    logic             cs_n = 1'b1;
    logic [NCH-1:0]   smp_valid = '0;
    logic [NCH*SW-1:0] smp_data = '0;
    logic [NCH*8-1:0] act_gain;
    logic [NCH-1:0]   ch_muted;

    always #10 clk = ~clk;

    zc_gain_updater #(
        .NUM_CH(NCH), .SAMPLE_W(SW), .CLK_HZ(2000), .TIMEOUT_MS(16)
    ) u_zc_gain_updater (
        .clk(clk), .rst(rst), .upd_stb(upd_stb), .upd_code(upd_code),
        .zc_en(zc_en), .mute_n(mute_n), .cs_n(cs_n),
        .smp_valid(smp_valid), .smp_data(smp_data),
        .act_gain(act_gain), .ch_muted(ch_muted)
    );

    typedef struct {
        int          at;
        logic [15:0] gain;
        logic [1:0]  mut;
        string       tag;
    } exp_t;

    exp_t sb[$];
    int   cyc = 0;
    int   n_chk = 0;
    int   n_fail = 0;
    bit   done = 0;
    bit   neg_q [NCH];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic compare(input string tag, input logic [15:0] eg, input logic [1:0] em);
        n_chk++;
        if (act_gain !== eg || ch_muted !== em) begin
            n_fail++;
            $display("FAIL %s: act_gain=%h ch_muted=%b expected act_gain=%h ch_muted=%b",
                     tag, act_gain, ch_muted, eg, em);
        end
    endtask

    // Monitor: compares scoreboard entries due in the current cycle.
    always @(negedge clk) begin
        for (int i = sb.size() - 1; i >= 0; i--) begin
            if (sb[i].at == cyc) begin
                compare(sb[i].tag, sb[i].gain, sb[i].mut);
                sb.delete(i);
            end
        end
    end

    task automatic expect_at(input int at, input logic [15:0] eg, input logic [1:0] em,
                             input string tag);
        exp_t e;
        e.at = at; e.gain = eg; e.mut = em; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic strobe(input logic [7:0] c0, input logic [7:0] c1);
        upd_code = {c1, c0};
        upd_stb  = 1'b1;
        step(1);
        upd_stb  = 1'b0;
    endtask

    task automatic put_sample(input int ch, input bit flip);
        if (flip) neg_q[ch] = !neg_q[ch];
        smp_data[ch*SW +: SW] = neg_q[ch] ? 16'hE000 : 16'h1234;
        smp_valid[ch] = 1'b1;
        step(1);
        smp_valid[ch] = 1'b0;
    endtask

    task automatic put_zero(input int ch);
        neg_q[ch] = 1'b0;
        smp_data[ch*SW +: SW] = '0;
        smp_valid[ch] = 1'b1;
        step(1);
        smp_valid[ch] = 1'b0;
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        int t;
        neg_q[0] = 0;
        neg_q[1] = 0;
        step(3);
        rst = 1'b0;
        step(1);
        compare("R1 reset state", 16'h0000, 2'b11);

        // Prime sign history (first samples, positive: no crossing).
        smp_data  = {16'h1234, 16'h1234};
        smp_valid = 2'b11;
        step(1);
        smp_valid = 2'b00;

        // R2: direct load.
        zc_en = 1'b0;
        expect_at(cyc + 1, 16'h4080, 2'b00, "R2 immediate load");
        strobe(8'h80, 8'h40);
        step(2);

        // R3 / R4: two crossings, with invalid and same-sign samples between.
        zc_en = 1'b1;
        expect_at(cyc + 1, 16'h4080, 2'b00, "R3 held after strobe");
        strobe(8'h90, 8'h40);
        expect_at(cyc + 1, 16'h4080, 2'b00, "R3 one crossing only");
        put_sample(0, 1);
        smp_data[SW-1:0] = 16'h1234;
        expect_at(cyc + 1, 16'h4080, 2'b00, "R4 invalid cycle ignored");
        step(1);
        expect_at(cyc + 1, 16'h4080, 2'b00, "R4 same sign ignored");
        put_sample(0, 0);
        expect_at(cyc + 1, 16'h4090, 2'b00, "R3 second crossing applies");
        put_sample(0, 1);
        step(2);

        // R4 / R11: zero samples count as crossings; ch0 untouched.
        expect_at(cyc + 1, 16'h4090, 2'b00, "R11 ch1 held ch0 kept");
        strobe(8'h90, 8'h50);
        expect_at(cyc + 1, 16'h4090, 2'b00, "R4 first zero");
        put_zero(1);
        expect_at(cyc + 1, 16'h5090, 2'b00, "R4 second zero applies");
        put_zero(1);
        step(2);

        // R5: timeout with no samples.
        t = cyc;
        expect_at(t + TMO, 16'h5090, 2'b00, "R5 one edge before timeout");
        expect_at(t + TMO + 1, 16'h50A0, 2'b00, "R5 applied at timeout");
        strobe(8'hA0, 8'h50);
        step(TMO + 3);

        // R6: replacement restarts the window and the crossing count.
        t = cyc;
        expect_at(t + 1 + TMO, 16'h50A0, 2'b00, "R6 old window gone");
        expect_at(t + 20 + TMO, 16'h50A0, 2'b00, "R6 restarted window");
        expect_at(t + 21 + TMO, 16'h50C0, 2'b00, "R6 replacing code applied");
        strobe(8'hB0, 8'h50);
        step(3);
        put_sample(0, 1);
        step(t + 20 - cyc);
        strobe(8'hC0, 8'h50);
        step(2);
        put_sample(0, 1);
        step(t + 25 + TMO - cyc);

        // R7: code zero silences its channel.
        zc_en = 1'b0;
        expect_at(cyc + 1, 16'h00C0, 2'b10, "R7 zero code silences");
        strobe(8'hC0, 8'h00);
        expect_at(cyc + 1, 16'h50C0, 2'b00, "R7 nonzero code clears");
        strobe(8'hC0, 8'h50);
        step(2);

        // R8 / R11: pin mute per channel, gated even with zc_en low.
        t = cyc;
        expect_at(t + 2, 16'h50C0, 2'b00, "R8 waits for event");
        expect_at(t + 3, 16'h50C0, 2'b01, "R8 ch0 mutes at crossing");
        expect_at(t + TMO, 16'h50C0, 2'b01, "R11 ch1 still waiting");
        expect_at(t + TMO + 1, 16'h50C0, 2'b11, "R8 ch1 mutes at timeout");
        mute_n = 1'b0;
        step(2);
        put_sample(0, 1);
        step(t + TMO + 3 - cyc);

        // R10: release.
        t = cyc;
        expect_at(t + 1, 16'h50C0, 2'b11, "R10 not yet released");
        expect_at(t + 2, 16'h50C0, 2'b00, "R10 released");
        mute_n = 1'b1;
        step(4);

        // R9: mute deferred during a transfer.
        t = cyc;
        cs_n   = 1'b0;
        mute_n = 1'b0;
        expect_at(t + 4, 16'h50C0, 2'b00, "R9 deferred while cs_n low");
        step(3);
        put_sample(0, 1);
        step(t + 10 - cyc);
        cs_n = 1'b1;
        expect_at(t + 12, 16'h50C0, 2'b00, "R9 waiting after cs_n high");
        expect_at(t + 13, 16'h50C0, 2'b01, "R9 mute after transfer");
        expect_at(t + 16, 16'h50C0, 2'b00, "R10 waiting mute dropped");
        expect_at(t + 13 + TMO, 16'h50C0, 2'b00, "R10 ch1 never muted");
        step(2);
        put_sample(0, 1);
        step(1);
        mute_n = 1'b1;

        step(TMO + 20);
        done = 1;
        if (sb.size() != 0) begin
            n_chk++;
            n_fail++;
            $display("FAIL scoreboard: pending=%0d expected=0", sb.size());
        end
        summary();
        $finish;
    end

endmodule